// File: doc/BRIEF.md
# Hardware Spinlock Register Bank

This block is a bank of hardware semaphores on a simple synchronous register bus. Several processors use it to share resources. A processor asks for a semaphore by reading that semaphore's register. If the value returned is zero, the lock was free, and the same read has already marked it taken. If the value is one, another requester holds the lock and the caller tries again. Because the read both tests and sets the lock, requesters need no atomic read-modify-write bus operation. Any requester can release a lock by writing zero to its register. The bank does not check which requester owns a lock.

Two read-only words sit beside the lock registers. One is a status word that shows the taken state of every lock at once. The other is a fixed configuration word. Read data is registered: it appears on the cycle after the read strobe, and it is zero in every cycle that does not follow a read. The reset is synchronous and active high. While reset is held, the bank refuses every access.

Top module: `spl_bank`

## Requirements
- R1: In the cycle after reset is released, every lock is free and the status word at byte offset 0x10 reads 0.
- R2: Lock N sits at byte offset 0x100 + 4*N, for N from 0 to 31. A read of a free lock returns 0 on `rd_data` in the next cycle, and from then on the lock is taken. Taking one lock changes no other lock.
- R3: A read of a taken lock returns 1 and leaves the lock taken.
- R4: Writing the value 0 to a taken lock frees it. Any requester may do this.
- R5: A write of a nonzero value to a lock register changes nothing. A write to a lock that is already free also changes nothing.
- R6: In the status word, bit N is 1 exactly when lock N is taken, and bits 31..NUM_LOCKS read 0. The status word is read-only, and reading it takes no lock.
- R7: The configuration word at offset 0x0 always reads 0x10000000. Writes to it are ignored.
- R8: If a read and a write hit the same lock in the same cycle, the write acts first and the read returns, and acts on, the result.
- R9: A read of any unmapped offset returns 0, and a write to it changes nothing. A lock offset whose two low bits are not zero counts as unmapped.
- R10: While reset is held, a read returns 0 and takes no lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 12 | Byte offset of the access |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |

## Verification
The bench walks every lock through take, retry, ignored nonzero write and release. After each step it reads the status word and compares it with a model vector in the bench. A bank that did not set a lock on a read would return 0 twice in a row. A design that decoded the address wrongly would set or clear the wrong status bit. The bench also fires a read and a write at one lock in the same cycle. A design with the wrong ordering would return 1 where 0 is due, or would leave the lock free. It sweeps unmapped and misaligned offsets, where a loose decoder would free a neighbouring lock. Finally it reads while reset is held, where a design that ignored reset would return 0 but leave the lock taken afterwards.

// File: rtl/spl_pkg.sv
package spl_pkg;

    parameter int ADDR_W        = 12;
    parameter int DATA_W        = 32;
    parameter int NUM_LOCKS_DEF = 32;

    parameter logic [ADDR_W-1:0] CFG_OFF    = 12'h000;
    parameter logic [ADDR_W-1:0] STATUS_OFF = 12'h010;
    parameter logic [ADDR_W-1:0] LOCK_BASE  = 12'h100;
    parameter logic [DATA_W-1:0] CFG_VALUE  = 32'h1000_0000;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CFG,
        SEL_STATUS,
        SEL_LOCK
    } sel_kind_e;

    typedef struct packed {
        sel_kind_e         kind;
        logic [ADDR_W-1:0] idx;
    } reg_sel_t;

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a, input int n_locks);
        reg_sel_t s;
        logic [ADDR_W-1:0] off;
        s.kind = SEL_NONE;
        s.idx  = '0;
        off    = a - LOCK_BASE;
        if (a == CFG_OFF) begin
            s.kind = SEL_CFG;
        end else if (a == STATUS_OFF) begin
            s.kind = SEL_STATUS;
        end else if (a >= LOCK_BASE && a[1:0] == 2'b00 &&
                     ({20'd0, off} >> 2) < n_locks) begin
            s.kind = SEL_LOCK;
            s.idx  = off >> 2;
        end
        return s;
    endfunction

endpackage

// File: rtl/spl_decoder.sv
module spl_decoder
    import spl_pkg::*;
#(
    parameter int NUM_LOCKS = NUM_LOCKS_DEF
) (
    input  logic              strobe,
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel,
    output logic [NUM_LOCKS-1:0] lock_hit
);
    always_comb begin
        sel = decode_addr(addr, NUM_LOCKS);
        if (!strobe) sel.kind = SEL_NONE;
    end

    for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_hit
        assign lock_hit[i] = (sel.kind == SEL_LOCK) && (sel.idx == ADDR_W'(i));
    end
endmodule

// File: rtl/spl_lock_cell.sv
module spl_lock_cell (
    input  logic clk,
    input  logic rst,
    input  logic rd_hit,
    input  logic wr_hit,
    input  logic wr_zero,
    output logic taken_q,
    output logic taken_seen
);
    // write acts first; the read observes and then sets
    always_comb taken_seen = (wr_hit && wr_zero) ? 1'b0 : taken_q;

    always_ff @(posedge clk) begin
        if (rst)         taken_q <= 1'b0;
        else if (rd_hit) taken_q <= 1'b1;
        else             taken_q <= taken_seen;
    end
endmodule

// File: rtl/spl_read_mux.sv
module spl_read_mux
    import spl_pkg::*;
#(
    parameter int NUM_LOCKS = NUM_LOCKS_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  reg_sel_t             rsel,
    input  logic [NUM_LOCKS-1:0] lock_q,
    input  logic [NUM_LOCKS-1:0] lock_seen,
    output logic [DATA_W-1:0]    rd_data
);
    logic [DATA_W-1:0] value;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        unique case (rsel.kind)
            SEL_CFG:    value = CFG_VALUE;
            SEL_STATUS: value = DATA_W'(lock_q);
            SEL_LOCK:   value = DATA_W'(lock_seen[rsel.idx[$clog2(NUM_LOCKS)-1:0]]);
            default:    value = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rdata_q <= '0;
        else     rdata_q <= value;
    end

    assign rd_data = rdata_q;
endmodule

// File: rtl/spl_bank.sv
module spl_bank
    import spl_pkg::*;
#(
    parameter int NUM_LOCKS = NUM_LOCKS_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    reg_sel_t             rsel;
    reg_sel_t             wsel;
    logic [NUM_LOCKS-1:0] rd_hit;
    logic [NUM_LOCKS-1:0] wr_hit;
    logic [NUM_LOCKS-1:0] lock_q;
    logic [NUM_LOCKS-1:0] lock_seen;
    logic                 wr_zero;

    assign wr_zero = (wr_data == '0);

    spl_decoder #(.NUM_LOCKS(NUM_LOCKS)) u_rdec (
        .strobe(rd_en && !rst), .addr(addr), .sel(rsel), .lock_hit(rd_hit)
    );
    spl_decoder #(.NUM_LOCKS(NUM_LOCKS)) u_wdec (
        .strobe(wr_en && !rst), .addr(addr), .sel(wsel), .lock_hit(wr_hit)
    );

    for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_lock
        spl_lock_cell u_cell (
            .clk(clk), .rst(rst),
            .rd_hit(rd_hit[i]), .wr_hit(wr_hit[i]), .wr_zero(wr_zero),
            .taken_q(lock_q[i]), .taken_seen(lock_seen[i])
        );
    end

    spl_read_mux #(.NUM_LOCKS(NUM_LOCKS)) u_rmux (
        .clk(clk), .rst(rst), .rsel(rsel),
        .lock_q(lock_q), .lock_seen(lock_seen), .rd_data(rd_data)
    );
endmodule

// File: rtl/spl_bank_chk.sv
module spl_bank_chk
    import spl_pkg::*;
#(
    parameter int NUM_LOCKS = NUM_LOCKS_DEF
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 rd_en,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    addr,
    input logic [DATA_W-1:0]    wr_data,
    input logic [DATA_W-1:0]    rd_data,
    input logic [NUM_LOCKS-1:0] lock_q
);
    logic            is_lock;
    logic            is_unmapped;
    int unsigned     li;
    logic            cur_taken;

    always_comb begin
        li          = 32'(addr - LOCK_BASE) >> 2;
        is_lock     = addr >= LOCK_BASE && addr[1:0] == 2'b00 && li < NUM_LOCKS;
        is_unmapped = !is_lock && addr != CFG_OFF && addr != STATUS_OFF;
        cur_taken   = is_lock ? lock_q[li[$clog2(NUM_LOCKS)-1:0]] : 1'b0;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) && !rst |-> lock_q == '0);

    assert_take_R2: assert property (@(posedge clk) disable iff (rst)
        rd_en && !wr_en && is_lock && !cur_taken |=> rd_data == '0 && $countones(lock_q) == $countones($past(lock_q)) + 1);

    assert_retry_R3: assert property (@(posedge clk) disable iff (rst)
        rd_en && !wr_en && is_lock && cur_taken |=> rd_data == 32'd1 && $stable(lock_q));

    assert_free_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en && !rd_en && is_lock && cur_taken && wr_data == '0 |=> $countones(lock_q) + 1 == $countones($past(lock_q)));

    assert_nonzero_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en && !rd_en && wr_data != '0 |=> $stable(lock_q));

    assert_cfg_R7: assert property (@(posedge clk) disable iff (rst)
        rd_en && addr == CFG_OFF |=> rd_data == CFG_VALUE);

    assert_same_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        rd_en && wr_en && is_lock && wr_data == '0 |=> rd_data == '0);

    assert_unmapped_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en || wr_en) && is_unmapped |=> rd_data == '0 && $stable(lock_q));
endmodule

bind spl_bank spl_bank_chk #(.NUM_LOCKS(NUM_LOCKS)) u_chk (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .lock_q(lock_q)
);

// File: tb/spl_bank_bench.sv
module spl_bank_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] mdl = '0;

    always #10 clk = ~clk;

    spl_bank u_spl_bank (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
    );

    function automatic logic [11:0] lock_addr(input int n);
        return 12'(12'h100 + 4 * n);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus(input logic r, input logic w, input logic [11:0] a,
                       input logic [31:0] d, output logic [31:0] q);
        @(negedge clk);
        rd_en = r; wr_en = w; addr = a; wr_data = d;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        q = rd_data;
    endtask

    task automatic check_status(input string tag);
        logic [31:0] q;
        bus(1'b1, 1'b0, 12'h010, 32'h0, q);
        check(tag, q, mdl);
    endtask

    initial begin
        logic [31:0] q;
        // R10: read while reset is held
        repeat (2) @(negedge clk);
        bus(1'b1, 1'b0, lock_addr(5), 32'h0, q);
        check("R10 read during reset", q, 32'h0);
        @(negedge clk); rst = 1'b0;
        check_status("R1 status after reset");
        check_status("R10 lock not taken under reset");

        bus(1'b1, 1'b0, 12'h000, 32'h0, q);
        check("R7 config word", q, 32'h1000_0000);

        for (int i = 0; i < 32; i++) begin
            bus(1'b1, 1'b0, lock_addr(i), 32'h0, q);
            check("R2 take free lock", q, 32'h0);
            mdl[i] = 1'b1;
            check_status("R2 R6 status after take");
            bus(1'b1, 1'b0, lock_addr(i), 32'h0, q);
            check("R3 retry taken lock", q, 32'h1);
        end
        check_status("R3 status unchanged");
        check_status("R6 status read has no side effect");

        for (int i = 0; i < 32; i++) begin
            bus(1'b0, 1'b1, lock_addr(i), 32'(i + 1), q);
        end
        check_status("R5 nonzero writes ignored");

        for (int i = 1; i < 32; i += 2) begin
            bus(1'b0, 1'b1, lock_addr(i), 32'h0, q);
            mdl[i] = 1'b0;
            check_status("R4 release lock");
        end
        for (int i = 1; i < 32; i += 2) begin
            bus(1'b0, 1'b1, lock_addr(i), 32'h0, q);
        end
        check_status("R5 write to free lock");

        // R8: same-cycle read and write
        bus(1'b1, 1'b1, lock_addr(0), 32'h0, q);
        check("R8 taken lock freed then retaken", q, 32'h0);
        check_status("R8 status after lock 0");
        bus(1'b1, 1'b1, lock_addr(1), 32'h0, q);
        check("R8 free lock taken", q, 32'h0);
        mdl[1] = 1'b1;
        check_status("R8 status after lock 1");
        bus(1'b1, 1'b1, lock_addr(2), 32'h5, q);
        check("R8 nonzero write keeps lock", q, 32'h1);

        // R7 / R6 writes to read-only words
        bus(1'b0, 1'b1, 12'h000, 32'h0, q);
        bus(1'b1, 1'b0, 12'h000, 32'h0, q);
        check("R7 config after write", q, 32'h1000_0000);
        bus(1'b0, 1'b1, 12'h010, 32'h0, q);
        check_status("R6 status write ignored");

        // R9 unmapped and misaligned
        foreach (mdl[k]) begin end
        for (int k = 0; k < 10; k++) begin
            logic [11:0] ua;
            case (k)
                0: ua = 12'h004; 1: ua = 12'h008; 2: ua = 12'h00C; 3: ua = 12'h014;
                4: ua = 12'h080; 5: ua = 12'h101; 6: ua = 12'h102; 7: ua = 12'h180;
                8: ua = 12'h103; default: ua = 12'hFFC;
            endcase
            bus(1'b1, 1'b0, ua, 32'h0, q);
            check("R9 unmapped read", q, 32'h0);
            bus(1'b0, 1'b1, ua, 32'h0, q);
        end
        check_status("R9 unmapped writes ignored");

        // R1 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        mdl = '0;
        check_status("R1 status after second reset");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule